// File: doc/BRIEF.md
# Neural Multiply-Accumulate Processing Element

This block is one cell of a grid that evaluates a small feed-forward neural network. Each cell owns a private store of signed weights and a pointer into that store. A central sequencer drives every cell through one shared two-bit command bus. The commands clear the running sum, load a weight, or fold the present neuron state into the sum. Because the weights and the address walk are local, the same grid can be reloaded and reused for each layer of the network without streaming weights in during evaluation.

Neuron states arrive as 8-bit signed samples with a valid flag. In the intended system a new sample appears every third clock cycle. Each sample is multiplied by the 16-bit signed weight under the pointer and added to a 29-bit signed running sum, which goes out toward the row summation logic. Every incoming sample, with its valid flag, is also sent one cycle later on a neighbour port, so states can ripple along a grid row.

Top module: `nmac_pe`

## Requirements
- R1: While reset is asserted (active-low, asynchronous), the running sum, the forwarded state and the forwarded valid flag are all zero, and the weight pointer is at entry 0.
- R2: Command code 01 sets the running sum to zero and the weight pointer to entry 0 at the next clock edge. The next fold then uses the weight at entry 0.
- R3: Command code 10 with the sample valid flag high adds the product of the signed state and the signed weight under the pointer to the running sum. The new sum is visible at the output after the next clock edge. Up to 32 full-scale products after a clear never overflow the 29-bit sum.
- R4: Every fold (R3) and every weight load (R7) moves the pointer up by one, and it wraps from the last entry (31 by default) back to entry 0.
- R5: Command code 00 leaves the running sum and the pointer unchanged.
- R6: On every clock edge, whatever the command, the forwarded state and valid flag take the values the state and valid inputs had just before that edge.
- R7: Command code 11 writes the load-port word into the entry under the pointer and advances the pointer. The running sum is not changed.
- R8: Command code 10 with the sample valid flag low changes neither the running sum nor the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Broadcast command: 00 hold, 01 clear, 10 fold, 11 load weight |
| state_i | input | 8 | Signed neuron state sample |
| state_vld_i | input | 1 | Marks state_i as a valid sample |
| wload_i | input | 16 | Signed weight word for command 11 |
| data_o | output | 8 | State forwarded to the neighbouring cell, delayed one cycle |
| data_vld_o | output | 1 | Valid flag forwarded with data_o |
| acc_o | output | 29 | Signed running sum |

## Verification
A pointer that is off by one, or wraps at the wrong entry, pairs each state with a neighbouring weight. The error shows up in acc_o at the first fold after the fault, one cycle after that fold's command. The bench therefore compares the sum after every fold, and also after clears, loads, holds and invalid folds. A product that is sign-extended or truncated wrongly shows up only for negative or full-scale operands, so the bench runs a full-scale series all the way to the wrap point. A stalled forwarding register is caught on the very next cycle at data_o.

// File: rtl/nmac_pkg.sv
package nmac_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'b00,
    CMD_CLR  = 2'b01,
    CMD_FOLD = 2'b10,
    CMD_WLD  = 2'b11
  } nmac_cmd_e;
endpackage

// File: rtl/nmac_dec.sv
module nmac_dec
  import nmac_pkg::*;
(
  input  logic [1:0] cmd,
  input  logic       vld,
  output logic       clr,
  output logic       fold,
  output logic       wld,
  output logic       adv
);
  nmac_cmd_e c;
  always_comb begin
    c    = nmac_cmd_e'(cmd);
    clr  = (c == CMD_CLR);
    fold = (c == CMD_FOLD) && vld;
    wld  = (c == CMD_WLD);
    adv  = fold || wld;
  end
endmodule

// File: rtl/nmac_wmem.sv
module nmac_wmem #(
  parameter int unsigned DEPTH    = 32,
  parameter int unsigned WEIGHT_W = 16,
  localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       adv,
  input  logic                       wr_en,
  input  logic signed [WEIGHT_W-1:0] wr_data,
  output logic signed [WEIGHT_W-1:0] rd_data,
  output logic [AW-1:0]              addr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic signed [WEIGHT_W-1:0] mem [DEPTH];
  logic [AW-1:0] addr_nx;
  logic          at_last;

  always_comb begin
    at_last = (addr == LAST);
    addr_nx = addr;
    if (clr)      addr_nx = '0;
    else if (adv) addr_nx = at_last ? '0 : addr + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_nx;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wr_data;
  end

  assign rd_data = mem[addr];

  p_addr_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> addr == '0);
  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && at_last) |=> addr == '0);
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && !at_last) |=> addr == $past(addr) + AW'(1));
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(addr));
  p_wr_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(addr)] == $past(wr_data));
endmodule

// File: rtl/nmac_mac.sv
module nmac_mac #(
  parameter int unsigned STATE_W  = 8,
  parameter int unsigned WEIGHT_W = 16,
  parameter int unsigned ACC_W    = 29,
  localparam int unsigned PROD_W  = STATE_W + WEIGHT_W,
  localparam int unsigned SAFE_N  = (1 << (ACC_W - PROD_W + 1)) - 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       fold,
  input  logic signed [STATE_W-1:0]  state,
  input  logic signed [WEIGHT_W-1:0] weight,
  output logic signed [ACC_W-1:0]    acc
);
  function automatic logic signed [ACC_W-1:0] prod_ext(
    input logic signed [STATE_W-1:0]  s,
    input logic signed [WEIGHT_W-1:0] w);
    logic signed [PROD_W-1:0] p;
    p = s * w;
    return ACC_W'(p);
  endfunction

  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W:0]   sum_w;
  logic                    ovf_evt;

  always_comb begin
    prod    = prod_ext(state, weight);
    sum_w   = {acc[ACC_W-1], acc} + {prod[ACC_W-1], prod};
    ovf_evt = fold && (sum_w[ACC_W] ^ sum_w[ACC_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc <= '0;
    else if (clr)  acc <= '0;
    else if (fold) acc <= sum_w[ACC_W-1:0];
  end

  logic [7:0] folds_since_clr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                folds_since_clr <= '0;
    else if (clr)                              folds_since_clr <= '0;
    else if (fold && folds_since_clr != 8'hFF) folds_since_clr <= folds_since_clr + 8'd1;
  end

  p_acc_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc == '0);
  p_acc_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !fold) |=> $stable(acc));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && 32'(folds_since_clr) < SAFE_N) |-> !ovf_evt);
endmodule

// File: rtl/nmac_fwd.sv
module nmac_fwd #(
  parameter int unsigned STATE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] d,
  input  logic               d_vld,
  output logic [STATE_W-1:0] q,
  output logic               q_vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      q_vld <= 1'b0;
    end else begin
      q     <= d;
      q_vld <= d_vld;
    end
  end
endmodule

// File: rtl/nmac_pe.sv
module nmac_pe
  import nmac_pkg::*;
#(
  parameter int unsigned STATE_W  = 8,
  parameter int unsigned WEIGHT_W = 16,
  parameter int unsigned ACC_W    = 29,
  parameter int unsigned DEPTH    = 32,
  localparam int unsigned AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cmd_i,
  input  logic signed [STATE_W-1:0]  state_i,
  input  logic                       state_vld_i,
  input  logic signed [WEIGHT_W-1:0] wload_i,
  output logic signed [STATE_W-1:0]  data_o,
  output logic                       data_vld_o,
  output logic signed [ACC_W-1:0]    acc_o
);
  logic clr_w, fold_w, wld_w, adv_w;
  logic signed [WEIGHT_W-1:0] weight_w;
  logic [AW-1:0] addr_w;

  nmac_dec u_dec (
    .cmd  (cmd_i),
    .vld  (state_vld_i),
    .clr  (clr_w),
    .fold (fold_w),
    .wld  (wld_w),
    .adv  (adv_w)
  );

  nmac_wmem #(.DEPTH(DEPTH), .WEIGHT_W(WEIGHT_W)) u_wmem (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_w),
    .adv     (adv_w),
    .wr_en   (wld_w),
    .wr_data (wload_i),
    .rd_data (weight_w),
    .addr    (addr_w)
  );

  nmac_mac #(.STATE_W(STATE_W), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_w),
    .fold   (fold_w),
    .state  (state_i),
    .weight (weight_w),
    .acc    (acc_o)
  );

  logic [STATE_W-1:0] fwd_q;
  nmac_fwd #(.STATE_W(STATE_W)) u_fwd (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (state_i),
    .d_vld (state_vld_i),
    .q     (fwd_q),
    .q_vld (data_vld_o)
  );
  assign data_o = fwd_q;

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_HOLD) |=> $stable(acc_o));
  p_wld_acc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_WLD) |=> $stable(acc_o));
  p_fwd_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (data_vld_o == $past(state_vld_i)) && (data_o == $past(state_i)));
endmodule

// File: tb/tb_nmac_pe.sv
module tb_nmac_pe;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [1:0] cmd_i;
  logic signed [7:0] state_i;
  logic state_vld_i;
  logic signed [15:0] wload_i;
  logic signed [7:0] data_o;
  logic data_vld_o;
  logic signed [28:0] acc_o;

  nmac_pe dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .state_i(state_i),
    .state_vld_i(state_vld_i), .wload_i(wload_i),
    .data_o(data_o), .data_vld_o(data_vld_o), .acc_o(acc_o)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct { int exp; string tag; } item_t;
  item_t sbq[$];

  int mw[32];
  int maddr = 0;
  int macc = 0;

  bit fwd_pend = 1'b0;
  int fwd_exp_d;
  bit fwd_exp_v;

  // monitor: pops expected sums and forwarding values, compares away from the active edge
  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_run++;
      if (int'(acc_o) != it.exp) begin
        n_fail++;
        $display("FAIL %s acc_o actual=%0d expected=%0d", it.tag, int'(acc_o), it.exp);
      end
    end
    if (fwd_pend) begin
      fwd_pend = 1'b0;
      n_run++;
      if (int'(data_o) != fwd_exp_d || data_vld_o != fwd_exp_v) begin
        n_fail++;
        $display("FAIL R6 data_o/vld actual=%0d/%0b expected=%0d/%0b",
                 int'(data_o), data_vld_o, fwd_exp_d, fwd_exp_v);
      end
    end
  end

  task automatic step(input logic [1:0] c, input int s, input bit v,
                      input int wl, input bit push, input string tag);
    @(negedge clk);
    cmd_i = c; state_i = 8'(s); state_vld_i = v; wload_i = 16'(wl);
    @(posedge clk);
    case (c)
      2'b01: begin macc = 0; maddr = 0; end
      2'b10: if (v) begin
        macc = macc + int'($signed(8'(s))) * int'($signed(16'(wl_dummy(maddr))));
        maddr = (maddr + 1) % 32;
      end
      2'b11: begin mw[maddr] = int'($signed(16'(wl))); maddr = (maddr + 1) % 32; end
      default: ;
    endcase
    fwd_exp_d = int'($signed(8'(s)));
    fwd_exp_v = v;
    fwd_pend = 1'b1;
    if (push) sbq.push_back('{macc, tag});
  endtask

  function automatic int wl_dummy(input int a);
    return mw[a];
  endfunction

  function automatic int rnd8();
    return int'($signed(8'($urandom)));
  endfunction

  function automatic int rnd16();
    return int'($signed(16'($urandom)));
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cmd_i = 2'b00; state_i = 8'sd55; state_vld_i = 1'b1; wload_i = '0;
    repeat (3) @(negedge clk);
    n_run++;
    if (acc_o != 0 || data_o != 0 || data_vld_o != 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset acc/data/vld actual=%0d/%0d/%0b expected=0/0/0",
               int'(acc_o), int'(data_o), data_vld_o);
    end
    state_i = '0; state_vld_i = 1'b0;
    rst_n = 1'b1;

    // R1: pointer at 0 out of reset; R7: sequential weight loading
    for (int i = 0; i < 32; i++) step(2'b11, 0, 0, rnd16(), i == 0, "R7");
    // pointer wrapped to 0 after 32 loads (R4): fold uses entry 0
    step(2'b10, 3, 1, 0, 1, "R4");
    step(2'b01, 0, 0, 0, 1, "R2");

    // R3: dot product at a one-in-three cadence, holds in between (R5)
    for (int i = 0; i < 32; i++) begin
      step(2'b10, rnd8(), 1, 0, 1, "R3");
      step(2'b00, rnd8(), 0, 0, 1, "R5");
      step(2'b00, rnd8(), 1, 0, 1, "R5");
    end
    // R4: wrap back to entry 0 after the last entry
    step(2'b10, -77, 1, 0, 1, "R4");
    // R8: fold with invalid sample changes nothing
    step(2'b10, 99, 0, 0, 1, "R8");
    step(2'b10, 99, 0, 0, 1, "R8");
    step(2'b10, -5, 1, 0, 1, "R8");   // must use entry 1
    // R7: load while sum is nonzero leaves the sum alone, new weight at entry 2
    step(2'b11, 0, 0, -1234, 1, "R7");
    step(2'b01, 0, 0, 0, 1, "R2");
    step(2'b10, 11, 1, 0, 1, "R2");    // entry 0 after clear
    step(2'b10, 13, 1, 0, 1, "R3");
    step(2'b10, 17, 1, 0, 1, "R7");    // entry 2 holds -1234
    // R2: clear in mid-series
    step(2'b10, 21, 1, 0, 1, "R3");
    step(2'b01, 0, 1, 0, 1, "R2");
    step(2'b10, -9, 1, 0, 1, "R2");

    // R3: full-scale series, largest positive products
    step(2'b01, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 32; i++) step(2'b11, 0, 0, -32768, 0, "R7");
    for (int i = 0; i < 32; i++) step(2'b10, -128, 1, 0, 1, "R3");
    // R3: largest negative products
    step(2'b01, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 32; i++) step(2'b10, 127, 1, 0, 1, "R3");
    // alternating extremes
    step(2'b01, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 16; i++) step(2'b11, 0, 0, (i % 2) ? 32767 : -32768, 0, "R7");
    step(2'b01, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 32; i++) step(2'b10, (i % 3 == 0) ? -128 : 127, 1, 0, 1, "R3");

    step(2'b00, 0, 0, 0, 1, "R5");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule